// File: doc/BRIEF.md
# Upload Command Capture Buffer

This block records flash-style commands that are marked for software handling, so that firmware can deal with them after the host transaction has ended. It watches the byte stream that an upstream command parser produces. Each byte carries a phase tag that says whether it is the opcode, an address byte, a payload byte or another byte. The descriptor bits for the current command are presented beside the opcode byte. For a command marked for upload, the opcode goes into a command queue, the address (when the command has one) goes into an address queue, and every payload byte is written into a fixed 256-byte area of a 32-bit wide memory. Each write there is a single-byte write selected by a byte strobe.

Software drains the two queues through pop strobes and reads their head entries, levels and sticky overflow flags. It reads how many payload bytes the latest uploaded command carried. It clears the busy flag, which a command can set when it is captured. The payload area behaves as a ring: a payload longer than the area overwrites it from the start. The memory itself sits outside this block.

Top module: `upload_capture`

## Requirements
- R1: An opcode byte (phase 0) whose descriptor has the upload bit set is pushed into the command queue and appears as `cmd_head` on an empty queue, with `cmd_level` raised, one cycle after the byte. An opcode without the upload bit is not pushed.
- R2: Both queues hold 16 entries and return them first in, first out. `cmd_pop`/`addr_pop` remove the head one cycle later. A pop on an empty queue changes nothing.
- R3: A push into a full queue with no pop in the same cycle is dropped, and the level stays at 16. The queue's overflow flag is then set, and it stays set until reset.
- R4: When the uploaded command has an address field (`desc_addr_en`=1), its address bytes (phase 1) are gathered most significant byte first. There are three of them when `desc_addr_4b`=0, zero-extended to 32 bits, and four when it is 1. The result is pushed into the address queue in the cycle after the last address byte. Without an address field nothing is pushed, and address bytes beyond the needed count are ignored.
- R5: One cycle after each payload byte (phase 2) of an uploaded command, `mem_req`=`mem_we`=1. `mem_addr` is the payload base word (default 832) plus the byte pointer divided by 4. `mem_strb` has only bit (pointer mod 4) set, and the byte sits in lane (pointer mod 4) of `mem_wdata`, i.e. bits 8*lane to 8*lane+7.
- R6: The byte pointer starts at 0 with each uploaded opcode and wraps from 255 to 0, so byte 257 of a payload rewrites word 0, lane 0.
- R7: `pay_count` resets to 0 on each uploaded opcode, rises by one per payload byte and saturates at 256.
- R8: `busy` rises one cycle after an uploaded opcode whose busy bit is set. The busy bit is ignored when the upload bit is clear. `busy_clr` clears the flag one cycle later.
- R9: Address and payload bytes of a command without the upload bit cause no memory write, no push and no change of `pay_count`.
- R10: After reset the levels, overflow flags, `pay_count`, `busy` and `mem_req` are 0, and `mem_req` is 0 in every cycle that follows no payload byte of an uploaded command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A received byte is present |
| in_phase | input | 2 | Byte tag: 0 opcode, 1 address, 2 payload, 3 other |
| in_byte | input | 8 | Received byte |
| desc_upload | input | 1 | Descriptor: command is captured for software (sampled with the opcode) |
| desc_busy | input | 1 | Descriptor: capture sets the busy flag |
| desc_addr_en | input | 1 | Descriptor: command has an address field |
| desc_addr_4b | input | 1 | Descriptor: address is 4 bytes rather than 3 |
| cmd_pop | input | 1 | Remove the command queue head |
| addr_pop | input | 1 | Remove the address queue head |
| busy_clr | input | 1 | Clear the busy flag |
| mem_req | output | 1 | Memory write request |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 10 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes |
| cmd_head | output | 8 | Oldest queued opcode |
| cmd_level | output | 5 | Command queue occupancy |
| cmd_ovf | output | 1 | Sticky command queue overflow |
| addr_head | output | 32 | Oldest queued address |
| addr_level | output | 5 | Address queue occupancy |
| addr_ovf | output | 1 | Sticky address queue overflow |
| pay_count | output | 9 | Payload bytes of the latest uploaded command, saturating |
| busy | output | 1 | Busy status flag |

## Verification
The directed commands cover the two address widths and a command with no address. They tell zero-extension apart from byte-order mistakes. A command with the upload bit clear but every other bit set shows whether the upload bit gates all effects. A 260-byte payload separates ring wrap from count saturation, since the pointer returns to word 0 while the count holds at 256. Random command mixes with interleaved pops, including runs that fill a queue past 16, check queue order, drop-on-full and the sticky flags against a bench model.

// File: rtl/upl_pkg.sv
// Shared definitions for the upload capture buffer.
// Assumes the upstream parser tags every byte with one of the phases below.
package upl_pkg;
    typedef enum logic [1:0] {
        PH_OPCODE  = 2'd0,
        PH_ADDR    = 2'd1,
        PH_PAYLOAD = 2'd2,
        PH_OTHER   = 2'd3
    } phase_e;

    localparam int WORD_BYTES = 4;
    localparam int LANE_W     = $clog2(WORD_BYTES);
endpackage : upl_pkg

// File: rtl/upl_fifo.sv
// Synchronous queue with head output, level and sticky overflow flag.
// Assumes DEPTH is a power of two so the pointers wrap by themselves.
// A pop on empty is ignored; a push on full is dropped unless a pop frees room.
module upl_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          ovf
);
    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_pop, do_push, full;

    // Qualify the requests against the current occupancy.
    always_comb begin
        full    = (level == LW'(DEPTH));
        do_pop  = pop && (level != '0);
        do_push = push && (!full || do_pop);
    end

    assign head = store[rd_ptr];

    // Pointers, level and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
            if (push && !do_push) ovf <= 1'b1;
        end
    end

    // Entry storage, written on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= wdata;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));                                           // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);                                                   // R3
    AST_DROP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && level == LW'(DEPTH)) |=> (level == LW'(DEPTH) && ovf)); // R3
endmodule : upl_fifo

// File: rtl/upl_addr_asm.sv
// Gathers a 3- or 4-byte address, most significant byte first.
// Assumes start arrives with each opcode; need is zero for commands whose
// address is not captured, which makes every address byte be ignored.
module upl_addr_asm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        addr_en,
    input  logic        addr_4b,
    input  logic        byte_en,
    input  logic [7:0]  byte_in,
    output logic        push,
    output logic [31:0] value
);
    logic [23:0] acc;
    logic [2:0]  cnt, need;
    logic        take;

    // Accept a byte only while bytes are still owed.
    always_comb begin
        take  = byte_en && (cnt < need);
        push  = take && (cnt + 3'd1 == need);
        value = {acc, byte_in};
    end

    // Shift register and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            cnt  <= '0;
            need <= '0;
        end else if (start) begin
            acc  <= '0;
            cnt  <= '0;
            need <= addr_en ? (addr_4b ? 3'd4 : 3'd3) : 3'd0;
        end else if (take) begin
            acc <= {acc[15:0], byte_in};
            cnt <= cnt + 3'd1;
        end
    end

    AST_ADDR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= need);                                                   // R4
endmodule : upl_addr_asm

// File: rtl/upl_payload_wr.sv
// Turns payload bytes into single-strobe writes into a ring of words.
// Assumes start and wr_en never coincide (opcode and payload are distinct
// phases). Memory outputs are registered: one cycle after the byte.
module upl_payload_wr
    import upl_pkg::*;
#(
    parameter int RING_BYTES = 256,
    parameter int MEM_AW     = 10,
    parameter int BASE_WORD  = 832,
    localparam int PTR_W     = $clog2(RING_BYTES),
    localparam int CNT_W     = $clog2(RING_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  wr_en,
    input  logic [7:0]            byte_in,
    output logic                  mem_req,
    output logic [MEM_AW-1:0]     mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_wdata,
    output logic [WORD_BYTES-1:0] mem_strb,
    output logic [CNT_W-1:0]      count
);
    logic [PTR_W-1:0] ptr;

    // Byte pointer and saturating count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            count <= '0;
        end else if (start) begin
            ptr   <= '0;
            count <= '0;
        end else if (wr_en) begin
            ptr <= ptr + 1'b1;
            if (count != CNT_W'(RING_BYTES)) count <= count + 1'b1;
        end
    end

    // Registered memory write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_strb  <= '0;
        end else begin
            mem_req <= wr_en;
            if (wr_en) begin
                mem_addr  <= MEM_AW'(BASE_WORD) + MEM_AW'(ptr[PTR_W-1:LANE_W]);
                mem_wdata <= {WORD_BYTES{byte_in}};
                mem_strb  <= WORD_BYTES'(1) << ptr[LANE_W-1:0];
            end
        end
    end

    AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ($countones(mem_strb) == 1));                       // R5
    AST_REQ_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_req);                                             // R5
    AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !mem_req);                                           // R10
    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(RING_BYTES));                                   // R7
endmodule : upl_payload_wr

// File: rtl/upload_capture.sv
// Top of the upload capture buffer: command queue, address queue, payload
// ring writer and busy flag. Descriptor inputs are sampled with the opcode
// byte; later bytes use the upload decision latched at that point.
module upload_capture
    import upl_pkg::*;
#(
    parameter int CMD_DEPTH  = 16,
    parameter int ADDR_DEPTH = 16,
    parameter int RING_BYTES = 256,
    parameter int MEM_AW     = 10,
    parameter int BASE_WORD  = 832
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [1:0]                         in_phase,
    input  logic [7:0]                         in_byte,
    input  logic                               desc_upload,
    input  logic                               desc_busy,
    input  logic                               desc_addr_en,
    input  logic                               desc_addr_4b,
    input  logic                               cmd_pop,
    input  logic                               addr_pop,
    input  logic                               busy_clr,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [MEM_AW-1:0]                  mem_addr,
    output logic [31:0]                        mem_wdata,
    output logic [3:0]                         mem_strb,
    output logic [7:0]                         cmd_head,
    output logic [$clog2(CMD_DEPTH+1)-1:0]     cmd_level,
    output logic                               cmd_ovf,
    output logic [31:0]                        addr_head,
    output logic [$clog2(ADDR_DEPTH+1)-1:0]    addr_level,
    output logic                               addr_ovf,
    output logic [$clog2(RING_BYTES+1)-1:0]    pay_count,
    output logic                               busy
);
    logic        active;
    logic        op_seen, op_upload, addr_byte, pay_byte;
    logic        addr_push;
    logic [31:0] addr_value;

    // Decode the tagged byte stream.
    always_comb begin
        op_seen   = in_valid && (in_phase == PH_OPCODE);
        op_upload = op_seen && desc_upload;
        addr_byte = in_valid && (in_phase == PH_ADDR) && active;
        pay_byte  = in_valid && (in_phase == PH_PAYLOAD) && active;
    end

    // Remember whether the current command is being captured.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= 1'b0;
        else if (op_seen) active <= desc_upload;
    end

    // Busy flag: set by a captured busy command, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                       busy <= 1'b0;
        else if (op_upload && desc_busy)  busy <= 1'b1;
        else if (busy_clr)                busy <= 1'b0;
    end

    upl_fifo #(.W(8), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (op_upload),
        .wdata (in_byte),
        .pop   (cmd_pop),
        .head  (cmd_head),
        .level (cmd_level),
        .ovf   (cmd_ovf)
    );

    upl_addr_asm u_addr_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (op_seen),
        .addr_en (desc_addr_en && desc_upload),
        .addr_4b (desc_addr_4b),
        .byte_en (addr_byte),
        .byte_in (in_byte),
        .push    (addr_push),
        .value   (addr_value)
    );

    upl_fifo #(.W(32), .DEPTH(ADDR_DEPTH)) u_addr_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (addr_push),
        .wdata (addr_value),
        .pop   (addr_pop),
        .head  (addr_head),
        .level (addr_level),
        .ovf   (addr_ovf)
    );

    upl_payload_wr #(
        .RING_BYTES (RING_BYTES),
        .MEM_AW     (MEM_AW),
        .BASE_WORD  (BASE_WORD)
    ) u_pay (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (op_upload),
        .wr_en     (pay_byte),
        .byte_in   (in_byte),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_strb  (mem_strb),
        .count     (pay_count)
    );

    assign mem_we = mem_req;

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_seen && desc_upload && desc_busy));    // R8
    AST_CMD_PUSH_UPLOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_seen && !desc_upload && !cmd_pop) |=> $stable(cmd_level));  // R1
endmodule : upload_capture

// File: tb/upload_capture_bench.sv
module upload_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 832;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_phase;
    logic [7:0]  in_byte;
    logic        desc_upload, desc_busy, desc_addr_en, desc_addr_4b;
    logic        cmd_pop, addr_pop, busy_clr;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_strb;
    logic [7:0]  cmd_head;
    logic [4:0]  cmd_level, addr_level;
    logic        cmd_ovf, addr_ovf;
    logic [31:0] addr_head;
    logic [8:0]  pay_count;
    logic        busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    upload_capture u_upload_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
        .in_byte(in_byte), .desc_upload(desc_upload), .desc_busy(desc_busy),
        .desc_addr_en(desc_addr_en), .desc_addr_4b(desc_addr_4b),
        .cmd_pop(cmd_pop), .addr_pop(addr_pop), .busy_clr(busy_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_strb(mem_strb), .cmd_head(cmd_head),
        .cmd_level(cmd_level), .cmd_ovf(cmd_ovf), .addr_head(addr_head),
        .addr_level(addr_level), .addr_ovf(addr_ovf), .pay_count(pay_count),
        .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    logic [7:0]  cq[$];
    logic [31:0] aq[$];
    bit m_active, m_busy, m_cov, m_aov;
    int m_ptr, m_cnt, m_need, m_acnt;
    logic [31:0] m_acc;
    bit e_req;
    int e_addr, e_lane;
    logic [7:0] e_byte;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_word(input int ptr);
        return BASE + ptr / 4;
    endfunction

    task automatic check_all();
        chk("R1/R2 cmd_level", cmd_level, cq.size());
        chk("R4 addr_level", addr_level, aq.size());
        if (cq.size() > 0) chk("R1/R2 cmd_head", cmd_head, cq[0]);
        if (aq.size() > 0) chk("R4 addr_head", addr_head, aq[0]);
        chk("R3 cmd_ovf", cmd_ovf, m_cov);
        chk("R3 addr_ovf", addr_ovf, m_aov);
        chk("R7 pay_count", pay_count, m_cnt);
        chk("R8 busy", busy, m_busy);
        chk("R10 mem_req", mem_req, e_req);
        if (e_req) begin
            chk("R5 mem_we", mem_we, 1);
            chk("R5/R6 mem_addr", mem_addr, e_addr);
            chk("R5 mem_strb", mem_strb, 1 << e_lane);
            chk("R5 mem_wdata lane", mem_wdata[8*e_lane +: 8], e_byte);
        end
    endtask

    task automatic step(input logic [1:0] ph, input logic [7:0] b,
                        input bit up, input bit bz, input bit ae, input bit a4);
        @(negedge clk);
        in_valid = 1'b1; in_phase = ph; in_byte = b;
        desc_upload = up; desc_busy = bz; desc_addr_en = ae; desc_addr_4b = a4;
        e_req = 0;
        case (ph)
            2'd0: begin
                m_active = up;
                m_acnt = 0; m_acc = 0;
                m_need = (up && ae) ? (a4 ? 4 : 3) : 0;
                if (up) begin
                    if (cq.size() < 16) cq.push_back(b); else m_cov = 1;
                    m_ptr = 0; m_cnt = 0;
                    if (bz) m_busy = 1;
                end
            end
            2'd1: if (m_active && m_acnt < m_need) begin
                m_acc = {m_acc[23:0], b};
                m_acnt++;
                if (m_acnt == m_need) begin
                    if (aq.size() < 16) aq.push_back(m_acc); else m_aov = 1;
                end
            end
            2'd2: if (m_active) begin
                e_req = 1; e_addr = exp_word(m_ptr); e_lane = m_ptr % 4; e_byte = b;
                m_ptr = (m_ptr + 1) % 256;
                if (m_cnt < 256) m_cnt++;
            end
            default: ;
        endcase
        @(posedge clk); #1;
        check_all();
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; e_req = 0;
        @(posedge clk); #1;
        check_all();
    endtask

    task automatic pop(input bit c, input bit a);
        @(negedge clk);
        in_valid = 1'b0; e_req = 0;
        cmd_pop = c; addr_pop = a;
        if (c && cq.size() > 0) void'(cq.pop_front());
        if (a && aq.size() > 0) void'(aq.pop_front());
        @(posedge clk); #1;
        cmd_pop = 1'b0; addr_pop = 1'b0;
        check_all();
    endtask

    task automatic clear_busy();
        @(negedge clk);
        in_valid = 1'b0; e_req = 0; busy_clr = 1'b1; m_busy = 0;
        @(posedge clk); #1;
        busy_clr = 1'b0;
        check_all();
    endtask

    // Whole command: opcode, address bytes, payload bytes.
    task automatic command(input logic [7:0] op, input bit up, input bit bz,
                           input bit ae, input bit a4, input int nab, input int npay);
        step(2'd0, op, up, bz, ae, a4);
        for (int i = 0; i < nab; i++) step(2'd1, 8'($urandom_range(0, 255)), 0, 0, 0, 0);
        if ($urandom_range(0, 1) == 1) step(2'd3, 8'hAA, 0, 0, 0, 0);
        for (int i = 0; i < npay; i++) step(2'd2, 8'($urandom_range(0, 255)), 0, 0, 0, 0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_phase = 2'd0; in_byte = 8'h00;
        desc_upload = 0; desc_busy = 0; desc_addr_en = 0; desc_addr_4b = 0;
        cmd_pop = 0; addr_pop = 0; busy_clr = 0;
        m_active = 0; m_busy = 0; m_cov = 0; m_aov = 0;
        m_ptr = 0; m_cnt = 0; m_need = 0; m_acnt = 0; m_acc = 0; e_req = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all();                         // R10 reset state
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R1 R4 R5 R8: 3-byte address, busy set, short payload
        step(2'd0, 8'h02, 1, 1, 1, 0);
        step(2'd1, 8'h12, 0, 0, 0, 0);
        step(2'd1, 8'h34, 0, 0, 0, 0);
        step(2'd1, 8'h56, 0, 0, 0, 0);
        chk("R4 3-byte address zero-extended", addr_head, 32'h0012_3456);
        step(2'd1, 8'h78, 0, 0, 0, 0);      // R4 extra byte ignored
        for (int i = 0; i < 5; i++) step(2'd2, 8'(8'h10 + i), 0, 0, 0, 0);
        idle();

        // R8 R9: busy and address bits with upload clear have no effect
        clear_busy();
        command(8'h20, 0, 1, 1, 1, 4, 6);
        chk("R9 count kept after non-upload", pay_count, 5);

        // R4: 4-byte address
        step(2'd0, 8'hD8, 1, 0, 1, 1);
        step(2'd1, 8'hA1, 0, 0, 0, 0);
        step(2'd1, 8'hB2, 0, 0, 0, 0);
        step(2'd1, 8'hC3, 0, 0, 0, 0);
        step(2'd1, 8'hD4, 0, 0, 0, 0);
        chk("R4 4-byte address tail", aq[aq.size()-1], 32'hA1B2_C3D4);
        idle();

        // R6 R7: 260-byte payload wraps, count saturates
        command(8'h32, 1, 0, 0, 0, 0, 260);
        chk("R7 saturated count", pay_count, 256);

        // R2: drain, then pop empty
        while (cq.size() > 0 || aq.size() > 0) pop(1, 1);
        pop(1, 1);

        // R3: fill beyond 16
        for (int i = 0; i < 18; i++) command(8'(i + 8'h40), 1, 0, 1, 0, 3, 0);
        chk("R3 cmd level held at full", cmd_level, 16);
        while (cq.size() > 0 || aq.size() > 0) pop(1, 1);

        // Random mix with interleaved pops and busy clears
        for (int n = 0; n < 60; n++) begin
            command(8'($urandom_range(0, 255)), $urandom_range(0, 3) != 0,
                    $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 5), $urandom_range(0, 9));
            if ($urandom_range(0, 2) == 0) pop($urandom_range(0, 1), $urandom_range(0, 1));
            if ($urandom_range(0, 4) == 0) clear_busy();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule : upload_capture_bench